// File: doc/BRIEF.md
# Wide-Dividend Saturating Divider

This block divides a double-width dividend by a single-width divisor over many clock cycles. The dividend is formed by joining a high-part word, usually held in a dedicated register next to the datapath, with the low word of a general operand. The quotient is reduced to single width. It saturates to a fixed limit value when it cannot be represented, instead of wrapping. Unsigned and two's-complement signed division are both supported. Signed division truncates toward zero.

A request is a one-cycle start pulse. Along with the pulse come the mode selects, the high word, the operand and the divisor. The block then runs a restoring shift-subtract loop, one quotient bit per clock. It reports completion with a one-cycle done pulse and holds its outputs until the next accepted request. A zero divisor is caught at the request itself. It finishes on the following cycle with a fault flag and leaves the previous result untouched. When the set-flags select is on, an overflow flag reports saturation. The carry flag and both wide-result flags are always cleared.

Top module: `wide_sat_div`

## Requirements
- R1: After reset, result_o, done_o, busy_o, dz_fault_o and all four flag outputs read zero.
- R2: The dividend is {hi_i, opnd_i[31:0]}. The bits opnd_i[63:32] have no effect on the result.
- R3: In unsigned mode (signed_i=0), a quotient below 2^32 appears on result_o zero-extended to 64 bits.
- R4: In unsigned mode, a quotient of 2^32 or more gives result_o = 64'h00000000FFFFFFFF.
- R5: In signed mode (signed_i=1), dividend and divisor are two's complement. The quotient truncates toward zero, and a quotient in [-2^31, 2^31-1] appears sign-extended to 64 bits.
- R6: In signed mode, a non-negative quotient above 2^31-1 gives result_o = 64'h000000007FFFFFFF. This includes the most negative dividend divided by -1.
- R7: In signed mode, a negative quotient below -2^31 gives result_o = 64'hFFFFFFFF80000000. A quotient of exactly -2^31 is not saturated.
- R8: A request with divisor_i = 0 raises done_o and dz_fault_o in the cycle after the start edge. In that case result_o keeps its previous value and ovf_o reads 0.
- R9: A request with a non-zero divisor sets busy_o from the start edge on. done_o pulses for exactly one cycle, 65 clock edges after the start edge, and busy_o falls at the same edge.
- R10: A start pulse while busy_o is high is ignored. The running division completes with its original operands and on its original schedule.
- R11: When setflags_i was 1 at the start edge, ovf_o reports the saturation of R4, R6 or R7. Otherwise ovf_o is 0. carry_o, wide_ovf_o and wide_carry_o are always 0.
- R12: result_o, dz_fault_o and ovf_o change only at a done edge, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when not busy |
| signed_i | input | 1 | 1 = signed division, 0 = unsigned |
| setflags_i | input | 1 | 1 = report saturation on ovf_o |
| hi_i | input | 32 | Upper word of the dividend |
| opnd_i | input | 64 | Operand; its low word is the lower dividend word |
| divisor_i | input | 32 | Divisor |
| result_o | output | 64 | Saturated quotient |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Division in progress |
| dz_fault_o | output | 1 | Last request had a zero divisor |
| ovf_o | output | 1 | Saturation flag, valid from done |
| carry_o | output | 1 | Carry flag, always 0 |
| wide_ovf_o | output | 1 | Wide-result overflow flag, always 0 |
| wide_carry_o | output | 1 | Wide-result carry flag, always 0 |

## Verification
The assertions assume that reset is held low from time zero until the first clock edges have passed. They also assume that the mode selects and operands matter only in the cycle where start_i is accepted. The bench changes inputs only on falling edges, and it drives start_i for single cycles. It keeps the operands stable around each start pulse. One deliberate start pulse lands in the middle of a running division, so the acceptance property is exercised with busy_o high.

// File: rtl/wds_pkg.sv
// Package: shared definitions for the wide-dividend saturating divider.
// Assumes: nothing; holds only width-independent types.
package wds_pkg;

    // Division mode carried from request to completion.
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } div_mode_e;

    // Request attributes latched at acceptance.
    typedef struct packed {
        div_mode_e mode;
        logic      q_neg;
        logic      flags_en;
    } req_attr_t;

endpackage

// File: rtl/wds_prep.sv
// Module: wds_prep
// Builds the double-width dividend from the high word and the operand's low
// word. In signed mode it converts dividend and divisor to magnitudes and
// works out the quotient sign. The module is purely combinational.
// Assumes: the inputs are meaningful only in the cycle the request is accepted.
module wds_prep
    import wds_pkg::*;
#(
    parameter int W = 32
) (
    input  div_mode_e         mode_i,
    input  logic [W-1:0]      hi_i,
    input  logic [W-1:0]      lo_i,
    input  logic [W-1:0]      dvs_i,
    output logic [2*W-1:0]    dvd_mag_o,
    output logic [W-1:0]      dvs_mag_o,
    output logic              q_neg_o,
    output logic              dvs_zero_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic          dvd_neg;
    logic          dvs_neg;

    // Join the dividend and pick the operand signs.
    always_comb begin
        dvd_raw = {hi_i, lo_i};
        dvd_neg = (mode_i == MODE_SIGNED) && hi_i[W-1];
        dvs_neg = (mode_i == MODE_SIGNED) && dvs_i[W-1];
    end

    // Magnitudes, quotient sign and zero-divisor detect.
    always_comb begin
        dvd_mag_o  = dvd_neg ? (~dvd_raw + DW'(1)) : dvd_raw;
        dvs_mag_o  = dvs_neg ? (~dvs_i + W'(1)) : dvs_i;
        q_neg_o    = dvd_neg ^ dvs_neg;
        dvs_zero_o = (dvs_i == '0);
    end
endmodule

// File: rtl/wds_core.sv
// Module: wds_core
// Restoring shift-subtract engine. One quotient bit is made per step. The
// dividend register shifts left, and the new quotient bits enter at its bottom.
// After 2*W steps the register holds the full quotient magnitude.
// Assumes: the divisor magnitude is non-zero while stepping, and load and
// step are never high together.
module wds_core #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [2*W-1:0]    dvd_i,
    input  logic [W-1:0]      dvs_i,
    output logic [2*W-1:0]    quot_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] acc_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    trial;
    logic          fits;
    logic [W-1:0]  rem_n;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        trial = {rem_q, acc_q[DW-1]};
        fits  = (trial >= {1'b0, dvs_q});
        rem_n = fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
    end

    // Load operands, or take one step of the loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            acc_q <= dvd_i;
            rem_q <= '0;
            dvs_q <= dvs_i;
        end else if (step_i) begin
            acc_q <= {acc_q[DW-2:0], fits};
            rem_q <= rem_n;
        end
    end

    assign quot_o = acc_q;
endmodule

// File: rtl/wds_sat.sv
// Module: wds_sat
// Applies the quotient sign and limits the result to single width.
// Unsigned mode saturates to all ones in the low word. Signed mode saturates
// to the largest positive or the most negative single-width value,
// sign-extended to 2*W bits. The module is purely combinational.
// Assumes: q_mag_i is the quotient magnitude and q_neg_i is its sign.
module wds_sat
    import wds_pkg::*;
#(
    parameter int W = 32
) (
    input  div_mode_e         mode_i,
    input  logic              q_neg_i,
    input  logic [2*W-1:0]    q_mag_i,
    output logic [2*W-1:0]    res_o,
    output logic              sat_o
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] HALF    = DW'(1) << (W - 1);
    localparam logic [DW-1:0] U_MAX   = {{W{1'b0}}, {W{1'b1}}};
    localparam logic [DW-1:0] S_MAX   = HALF - DW'(1);
    localparam logic [DW-1:0] S_MIN   = ~S_MAX;

    // Pick the saturation test and limit that belong to the mode and sign.
    always_comb begin
        if (mode_i == MODE_UNSIGNED) begin
            sat_o = |q_mag_i[DW-1:W];
            res_o = sat_o ? U_MAX : {{W{1'b0}}, q_mag_i[W-1:0]};
        end else if (q_neg_i) begin
            sat_o = (q_mag_i > HALF);
            res_o = sat_o ? S_MIN : (~q_mag_i + DW'(1));
        end else begin
            sat_o = (q_mag_i > S_MAX);
            res_o = sat_o ? S_MAX : q_mag_i;
        end
    end
endmodule

// File: rtl/wide_sat_div.sv
// Module: wide_sat_div (top)
// A multi-cycle divider for a {hi, operand-low} dividend. It accepts a request
// when idle, runs 2*W restoring steps, then saturates and publishes the
// result with a one-cycle done pulse. A zero divisor finishes at once with a
// fault and leaves the result as it was.
// Assumes: a synchronous active-low reset, and start pulses that may arrive
// at any time (they are ignored while busy).
module wide_sat_div
    import wds_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic              setflags_i,
    input  logic [W-1:0]      hi_i,
    input  logic [2*W-1:0]    opnd_i,
    input  logic [W-1:0]      divisor_i,
    output logic [2*W-1:0]    result_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              dz_fault_o,
    output logic              ovf_o,
    output logic              carry_o,
    output logic              wide_ovf_o,
    output logic              wide_carry_o
);
    localparam int DW    = 2 * W;
    localparam int STEPS = DW;
    localparam int CW    = $clog2(STEPS + 1);

    div_mode_e     mode_in;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic          q_neg;
    logic          dvs_zero;
    logic [DW-1:0] q_mag;
    logic [DW-1:0] sat_res;
    logic          sat;
    logic          accept;
    logic          step;
    logic          unused_hi_opnd;

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;
    logic          dz_q;
    logic          ovf_q;
    logic [DW-1:0] res_q;
    req_attr_t     attr_q;

    // Request decode and loop stepping.
    always_comb begin
        mode_in = signed_i ? MODE_SIGNED : MODE_UNSIGNED;
        accept  = start_i && !busy_q;
        step    = busy_q && (cnt_q != '0);
    end

    assign unused_hi_opnd = ^opnd_i[DW-1:W];

    wds_prep #(.W(W)) u_prep (
        .mode_i     (mode_in),
        .hi_i       (hi_i),
        .lo_i       (opnd_i[W-1:0]),
        .dvs_i      (divisor_i),
        .dvd_mag_o  (dvd_mag),
        .dvs_mag_o  (dvs_mag),
        .q_neg_o    (q_neg),
        .dvs_zero_o (dvs_zero)
    );

    wds_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && !dvs_zero),
        .step_i (step),
        .dvd_i  (dvd_mag),
        .dvs_i  (dvs_mag),
        .quot_o (q_mag)
    );

    wds_sat #(.W(W)) u_sat (
        .mode_i  (attr_q.mode),
        .q_neg_i (attr_q.q_neg),
        .q_mag_i (q_mag),
        .res_o   (sat_res),
        .sat_o   (sat)
    );

    // Control: accept, count steps, finish and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            ovf_q  <= 1'b0;
            res_q  <= '0;
            attr_q <= '{mode: MODE_UNSIGNED, q_neg: 1'b0, flags_en: 1'b0};
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (dvs_zero) begin
                    done_q <= 1'b1;
                    dz_q   <= 1'b1;
                    ovf_q  <= 1'b0;
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= CW'(STEPS);
                    attr_q <= '{mode: mode_in, q_neg: q_neg, flags_en: setflags_i};
                end
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    dz_q   <= 1'b0;
                    res_q  <= sat_res;
                    ovf_q  <= attr_q.flags_en && sat;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    assign result_o     = res_q;
    assign done_o       = done_q;
    assign busy_o       = busy_q;
    assign dz_fault_o   = dz_q;
    assign ovf_o        = ovf_q;
    assign carry_o      = 1'b0;
    assign wide_ovf_o   = 1'b0;
    assign wide_carry_o = 1'b0;
endmodule

// File: rtl/wds_chk.sv
// Module: wds_chk
// Checker for wide_sat_div: protocol and hold properties on the top ports.
// Assumes: reset is low from time zero.
module wds_chk #(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [W-1:0]      divisor_i,
    input logic [2*W-1:0]    result_o,
    input logic              done_o,
    input logic              busy_o,
    input logic              dz_fault_o,
    input logic              ovf_o
);
    // R9: done is a single-cycle pulse.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: done never overlaps a running division.
    a_r9_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R10: an idle request with a non-zero divisor starts a run.
    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i != '0) |=> busy_o);

    // R12: the result moves only at a done edge.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R8: a fault completion leaves the result untouched.
    a_r8_dz_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_fault_o) |-> $stable(result_o));

    // R8: a fault never comes with overflow.
    a_r8_dz_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        dz_fault_o |-> !ovf_o);

    // R11: overflow can only appear with a completion.
    a_r11_ovf_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> done_o);
endmodule

bind wide_sat_div wds_chk #(.W(W)) u_wds_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .divisor_i  (divisor_i),
    .result_o   (result_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .dz_fault_o (dz_fault_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_wide_sat_div.sv
// Bench for wide_sat_div. A behavioural model tracks the expected outputs
// on every clock edge, and the bench compares them on every falling edge.
module test_wide_sat_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic        setflags_i = 1'b0;
    logic [31:0] hi_i = '0;
    logic [63:0] opnd_i = '0;
    logic [31:0] divisor_i = '0;
    logic [63:0] result_o;
    logic        done_o, busy_o, dz_fault_o, ovf_o, carry_o, wide_ovf_o, wide_carry_o;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    wide_sat_div i_wide_sat_div (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .setflags_i(setflags_i), .hi_i(hi_i), .opnd_i(opnd_i), .divisor_i(divisor_i),
        .result_o(result_o), .done_o(done_o), .busy_o(busy_o), .dz_fault_o(dz_fault_o),
        .ovf_o(ovf_o), .carry_o(carry_o), .wide_ovf_o(wide_ovf_o), .wide_carry_o(wide_carry_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Independent reference: saturated quotient and saturation flag.
    function automatic void ref_div(input bit sg, input logic [31:0] hi, input logic [31:0] lo,
                                    input logic [31:0] d, output logic [63:0] res, output bit sat);
        logic [63:0] a, b, ma, mb, mq;
        bit na, nb;
        a = {hi, lo};
        b = {{32{sg & d[31]}}, d};
        if (!sg) begin
            mq  = a / {32'h0, d};
            sat = (mq > 64'h0000_0000_FFFF_FFFF);
            res = sat ? 64'h0000_0000_FFFF_FFFF : mq;
        end else begin
            na = a[63];
            nb = b[63];
            ma = na ? -a : a;
            mb = nb ? -b : b;
            mq = ma / mb;
            if (na != nb) begin
                sat = (mq > 64'h0000_0000_8000_0000);
                res = sat ? 64'hFFFF_FFFF_8000_0000 : -mq;
            end else begin
                sat = (mq > 64'h0000_0000_7FFF_FFFF);
                res = sat ? 64'h0000_0000_7FFF_FFFF : mq;
            end
        end
    endfunction

    // Model state.
    bit          m_busy, m_done, m_dz, m_ovf, m_live;
    int          m_cnt;
    logic [63:0] m_res, m_pend;
    bit          m_pend_ovf;
    string       m_tag = "R3";
    string       cur_tag = "R3";

    // Reference model, one update per rising edge.
    always @(posedge clk) begin
        logic [63:0] r;
        bit s;
        m_live <= 1'b1;
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_dz <= 0; m_ovf <= 0; m_res <= '0; m_cnt <= 0;
        end else begin
            m_done <= 0;
            if (start_i && !m_busy) begin
                m_tag <= cur_tag;
                if (divisor_i == 0) begin
                    m_done <= 1; m_dz <= 1; m_ovf <= 0;
                end else begin
                    ref_div(signed_i, hi_i, opnd_i[31:0], divisor_i, r, s);
                    m_pend <= r;
                    m_pend_ovf <= s & setflags_i;
                    m_busy <= 1;
                    m_cnt <= 64;
                end
            end else if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy <= 0; m_done <= 1; m_dz <= 0;
                    m_res <= m_pend; m_ovf <= m_pend_ovf;
                end else m_cnt <= m_cnt - 1;
            end
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (m_live && !ended) begin
            chk(done_o == m_done, "R9 done", 64'(done_o), 64'(m_done));
            chk(busy_o == m_busy, "R9 busy", 64'(busy_o), 64'(m_busy));
            chk(result_o == m_res, m_done ? {m_tag, " result"} : "R12 hold",
                result_o, m_res);
            chk(dz_fault_o == m_dz, "R8 fault", 64'(dz_fault_o), 64'(m_dz));
            chk(ovf_o == m_ovf, "R11 ovf", 64'(ovf_o), 64'(m_ovf));
            chk({carry_o, wide_ovf_o, wide_carry_o} == 3'b000, "R11 zero flags",
                64'({carry_o, wide_ovf_o, wide_carry_o}), 64'h0);
        end
    end

    // One request; measures the latency to done.
    task automatic run_op(input bit sg, input bit fl, input logic [31:0] hi,
                          input logic [63:0] op, input logic [31:0] d, input string tag);
        int n = 0;
        @(negedge clk);
        cur_tag = tag;
        signed_i = sg; setflags_i = fl; hi_i = hi; opnd_i = op; divisor_i = d; start_i = 1;
        @(negedge clk);
        start_i = 0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == ((d == 0) ? 0 : 65), "R9 latency", 64'(n), (d == 0) ? 64'd0 : 64'd65);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run;
        ended = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        repeat (4) @(negedge clk);
        chk(result_o == 0 && !done_o && !busy_o && !dz_fault_o && !ovf_o, "R1 reset",
            {result_o[62:0], busy_o}, 64'h0);
        rst_n = 1;
        // R3 unsigned fits
        run_op(0, 1, 32'h0, 64'd100, 32'd7, "R3");
        run_op(0, 1, 32'h1, 64'd0, 32'd2, "R3");
        run_op(0, 1, 32'h2, 64'd0, 32'd3, "R3");
        // R4 unsigned saturation
        run_op(0, 1, 32'h3, 64'd0, 32'd3, "R4");
        run_op(0, 0, 32'h5, 64'd9, 32'd3, "R4");
        // R2 upper operand word ignored
        run_op(0, 1, 32'h0, 64'hDEAD_BEEF_0000_0064, 32'd7, "R2");
        // R5 signed truncation toward zero
        run_op(1, 1, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FF9C, 32'd7, "R5");
        run_op(1, 1, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FF9C, 32'hFFFF_FFF9, "R5");
        run_op(1, 1, 32'h0, 64'd100, 32'hFFFF_FFF9, "R5");
        run_op(1, 1, 32'hFFFF_FFFF, 64'h8000_0000, 32'd1, "R7 boundary");
        run_op(1, 1, 32'h0, 64'h4000_0000, 32'd1, "R5");
        // R6 positive saturation
        run_op(1, 1, 32'h0, 64'h8000_0000, 32'd1, "R6");
        run_op(1, 1, 32'h8000_0000, 64'h0, 32'hFFFF_FFFF, "R6");
        // R7 negative saturation
        run_op(1, 1, 32'hFFFF_FFFF, 64'h7FFF_FFFF, 32'd1, "R7");
        run_op(1, 0, 32'h0, 64'h8000_0001, 32'hFFFF_FFFF, "R7");
        // R8 zero divisor keeps result
        run_op(1, 1, 32'h1, 64'h5, 32'd0, "R8");
        run_op(0, 1, 32'h0, 64'd50, 32'd5, "R3");
        // R10: start while busy is ignored
        @(negedge clk);
        cur_tag = "R10";
        signed_i = 0; setflags_i = 0; hi_i = 0; opnd_i = 64'd1000; divisor_i = 32'd10; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (10) @(negedge clk);
        opnd_i = 64'd7; divisor_i = 32'd0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(busy_o == 1 && !done_o, "R10 ignored start", 64'(busy_o), 64'h1);
        while (!done_o) @(negedge clk);
        chk(result_o == 64'd100, "R10 original operands", result_o, 64'd100);
        repeat (2) @(negedge clk);
        // Pseudo-random mix
        seed = 32'h1234_5678;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] h, l, d;
            seed = seed * 32'd1664525 + 32'd1013904223; h = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; l = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; d = seed;
            if (k[0]) h = h >> 8;
            run_op(k[1], k[2], h, {32'hA5A5_A5A5, l}, d, k[1] ? "R5" : "R3");
        end
        finish_run();
    end
endmodule